// File: doc/BRIEF.md
# Multi-Slot Tick Timer Scheduler

This block runs a pool of logical timers from one shared time base. A free-running prescaler turns the input clock into a periodic tick, and every tick advances a tick counter. Each timer slot keeps an enable bit, the tick value at which it is due, and a reload period. A period of zero marks the slot as one-shot. After each tick the block visits the slots one per cycle, in ascending order. Any enabled slot whose due value equals the new count raises an expiry pulse that carries its slot number. A periodic slot is then pushed forward by its period. A one-shot slot is released.

Clients use a single request port. A create request gives a timeout in milliseconds and a periodic flag. The block takes the lowest-numbered free slot, converts the timeout to ticks and returns the slot number as a handle. If no slot is free, it reports an error. A delete request names a handle and releases that slot. Requests are held off while a tick is being taken or a scan is in progress. A slot is therefore never rewritten while the scan is reading it. Whatever the client does in response to an expiry is outside this block. The tick period in clock cycles, CLK_DIV*TICK_COUNTS, must be larger than NUM_SLOTS.

Top module: `slot_timer_sched`

## Requirements
- R1: A tick occurs once every CLK_DIV*TICK_COUNTS clock cycles (defaults 2 and 50000). Each tick adds one to `tick_count`.
- R2: While `rst` is high and in the cycle after it, `tick_count` is 0 and `fire_valid` and `ack` are low. `req_ready` is high after reset.
- R3: A create request (`req_op`=0) that is accepted takes the lowest-numbered free slot. It answers with `ack` high, `ack_ok`=1 and `ack_handle` set to that slot number.
- R4: A create request made while every slot is in use answers with `ack_ok`=0, which stands for the error handle. No slot changes.
- R5: A timeout becomes floor(ms/TICK_MS) ticks. A result of zero becomes 1, and a result above the counter range saturates. The slot is due at the `tick_count` seen when the request is accepted, plus that number of ticks (modulo 2^TW).
- R6: When the new `tick_count` equals the due value of an enabled slot, `fire_valid` is high for one cycle with `fire_slot` set to that slot number, during the scan that follows the tick.
- R7: A periodic slot fires again every period ticks until it is deleted.
- R8: A one-shot slot fires once and is then free, so it is the first slot offered to a later create.
- R9: A delete request (`req_op`=1) with a handle below NUM_SLOTS releases that slot, so it never fires again, and answers `ack_ok`=1. A handle of NUM_SLOTS or more answers `ack_ok`=0 and leaves every slot as it was.
- R10: Slots that fall due on the same tick fire on consecutive cycles, in ascending slot order.
- R11: `req_ready` is low in the tick cycle and for the NUM_SLOTS scan cycles that follow it. A request held during that time is taken only once `req_ready` is high. Its `ack` comes in the cycle after acceptance, never earlier.
- R12: `tick_count` and the due-value compare wrap modulo 2^TW, so a due value that wraps past the maximum count still fires after the correct number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 1 | 0 = create, 1 = delete |
| req_timeout_ms | input | MSW | Create timeout in milliseconds |
| req_periodic | input | 1 | Create: 1 = periodic, 0 = one-shot |
| req_handle | input | HW | Delete: slot to release |
| ack | output | 1 | One-cycle completion pulse |
| ack_ok | output | 1 | 1 = success, 0 = error |
| ack_handle | output | HW | Slot allocated or released |
| tick_count | output | TW | Current tick count |
| fire_valid | output | 1 | Expiry pulse |
| fire_slot | output | HW | Slot number of the expiry |

## Verification
The tick scan and a create or delete request can fall in the same cycle. The bench provokes this by raising a create request in the first cycle in which the new tick count is visible. It then counts the cycles in which `req_ready` stays low, which must be exactly NUM_SLOTS. It also confirms that `ack` stays low throughout that time and arrives one cycle after acceptance with the correct handle. Several slots created inside one tick interval with the same timeout must then fire on consecutive cycles in slot order.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic {
    OP_CREATE = 1'b0,
    OP_DELETE = 1'b1
  } sched_op_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int CLK_DIV     = 2,
  parameter int TICK_COUNTS = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (TICK_COUNTS > 1) ? $clog2(TICK_COUNTS) : 1;

  logic step;
  logic [PW-1:0] pre_q;

  generate
    if (CLK_DIV > 1) begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || div_q == DW'(CLK_DIV - 1)) div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign step = (div_q == DW'(CLK_DIV - 1));
    end else begin : g_nodiv
      assign step = 1'b1;
    end
  endgenerate

  assign tick = step && (pre_q == PW'(TICK_COUNTS - 1));

  always_ff @(posedge clk) begin
    if (rst)       pre_q <= '0;
    else if (tick) pre_q <= '0;
    else if (step) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ms_to_ticks.sv
module ms_to_ticks #(
  parameter int MSW     = 16,
  parameter int TW      = 16,
  parameter int TICK_MS = 100
) (
  input  logic [MSW-1:0] ms,
  output logic [TW-1:0]  ticks
);
  localparam int MAXT = (2 ** TW) - 1;

  logic [MSW-1:0] q;

  always_comb begin
    q = ms / MSW'(TICK_MS);
    if (q == '0)                    ticks = TW'(1);
    else if (32'(q) > 32'(MAXT))    ticks = '1;
    else                            ticks = TW'(q);
  end
endmodule

// File: rtl/first_free.sv
module first_free #(
  parameter int N  = 10,
  parameter int HW = 4
) (
  input  logic [N-1:0]  used,
  output logic          found,
  output logic [HW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = HW'(i);
      end
    end
  end
endmodule

// File: rtl/slot_timer_sched.sv
module slot_timer_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 10,
  parameter int CLK_DIV     = 2,
  parameter int TICK_COUNTS = 50000,
  parameter int TICK_MS     = 100,
  parameter int TW          = 16,
  parameter int MSW         = 16,
  localparam int HW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_op,
  input  logic [MSW-1:0] req_timeout_ms,
  input  logic           req_periodic,
  input  logic [HW-1:0]  req_handle,
  output logic           ack,
  output logic           ack_ok,
  output logic [HW-1:0]  ack_handle,
  output logic [TW-1:0]  tick_count,
  output logic           fire_valid,
  output logic [HW-1:0]  fire_slot
);
  localparam logic [HW:0]   NUM_W = (HW + 1)'(NUM_SLOTS);
  localparam logic [HW-1:0] LAST  = HW'(NUM_SLOTS - 1);

  logic                 tick_now;
  logic [NUM_SLOTS-1:0] en_q;
  logic [TW-1:0]        due_mem [NUM_SLOTS];
  logic [TW-1:0]        per_mem [NUM_SLOTS];
  logic                 busy_q;
  logic [HW-1:0]        idx_q;
  logic [TW-1:0]        tick_q;
  logic                 free_found;
  logic [HW-1:0]        free_idx;
  logic [TW-1:0]        req_ticks;

  tick_prescaler #(.CLK_DIV(CLK_DIV), .TICK_COUNTS(TICK_COUNTS)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_now)
  );

  first_free #(.N(NUM_SLOTS), .HW(HW)) u_free (
    .used(en_q), .found(free_found), .idx(free_idx)
  );

  ms_to_ticks #(.MSW(MSW), .TW(TW), .TICK_MS(TICK_MS)) u_conv (
    .ms(req_timeout_ms), .ticks(req_ticks)
  );

  logic          accept;
  logic          is_create;
  logic          del_in_range;
  logic [TW-1:0] scan_due;
  logic [TW-1:0] scan_per;
  logic          scan_hit;

  assign req_ready    = !busy_q && !tick_now;
  assign accept       = req_valid && req_ready;
  assign is_create    = (req_op == OP_CREATE);
  assign del_in_range = ({1'b0, req_handle} < NUM_W);
  assign scan_due     = due_mem[idx_q];
  assign scan_per     = per_mem[idx_q];
  assign scan_hit     = busy_q && en_q[idx_q] && (scan_due == tick_q);
  assign tick_count   = tick_q;

  // Slot storage: one write per cycle, no reset (RAM-friendly)
  always_ff @(posedge clk) begin
    if (scan_hit && scan_per != '0) begin
      due_mem[idx_q] <= scan_due + scan_per;
    end else if (accept && is_create && free_found) begin
      due_mem[free_idx] <= tick_q + req_ticks;
      per_mem[free_idx] <= req_periodic ? req_ticks : '0;
    end
  end

  // Tick count, scan sequencer, enables and responses
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      busy_q     <= 1'b0;
      idx_q      <= '0;
      tick_q     <= '0;
      fire_valid <= 1'b0;
      fire_slot  <= '0;
      ack        <= 1'b0;
      ack_ok     <= 1'b0;
      ack_handle <= '0;
    end else begin
      fire_valid <= 1'b0;
      ack        <= 1'b0;
      if (tick_now) begin
        tick_q <= tick_q + 1'b1;
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (scan_hit) begin
          fire_valid <= 1'b1;
          fire_slot  <= idx_q;
          if (scan_per == '0) en_q[idx_q] <= 1'b0;
        end
        if (idx_q == LAST) busy_q <= 1'b0;
        else               idx_q  <= idx_q + 1'b1;
      end
      if (accept) begin
        ack <= 1'b1;
        if (is_create) begin
          ack_ok     <= free_found;
          ack_handle <= free_found ? free_idx : '0;
          if (free_found) en_q[free_idx] <= 1'b1;
        end else begin
          ack_ok     <= del_in_range;
          ack_handle <= req_handle;
          if (del_in_range) en_q[req_handle] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/slot_timer_sched_chk.sv
module slot_timer_sched_chk #(
  parameter int NUM_SLOTS = 10,
  parameter int TW        = 16,
  localparam int HW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ack,
  input logic          ack_ok,
  input logic [HW-1:0] ack_handle,
  input logic [TW-1:0] tick_count,
  input logic          fire_valid,
  input logic [HW-1:0] fire_slot
);
  localparam logic [HW:0] NUM_W = (HW + 1)'(NUM_SLOTS);

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_count != $past(tick_count)) |-> (tick_count == TW'($past(tick_count) + 1'b1)));

  assert_handle_range_R3: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_ok) |-> ({1'b0, ack_handle} < NUM_W));

  assert_fire_range_R6: assert property (@(posedge clk) disable iff (rst)
    fire_valid |-> ({1'b0, fire_slot} < NUM_W));

  assert_fire_ascending_R10: assert property (@(posedge clk) disable iff (rst)
    (fire_valid && $past(fire_valid)) |-> (fire_slot > $past(fire_slot)));

  assert_stall_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
    (tick_count != $past(tick_count)) |-> !req_ready);

  assert_no_ack_when_stalled_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> !ack);
endmodule

bind slot_timer_sched slot_timer_sched_chk #(.NUM_SLOTS(NUM_SLOTS), .TW(TW)) u_chk (.*);

// File: tb/slot_timer_sched_bench.sv
module slot_timer_sched_bench;
  localparam int N      = 10;
  localparam int DIV    = 2;
  localparam int PRE    = 20;
  localparam int TW     = 8;
  localparam int HW     = 4;
  localparam int PERIOD = DIV * PRE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [15:0]   req_timeout_ms = '0;
  logic          req_periodic = 1'b0;
  logic [HW-1:0] req_handle = '0;
  logic          ack, ack_ok;
  logic [HW-1:0] ack_handle;
  logic [TW-1:0] tick_count;
  logic          fire_valid;
  logic [HW-1:0] fire_slot;

  slot_timer_sched #(.NUM_SLOTS(N), .CLK_DIV(DIV), .TICK_COUNTS(PRE),
                     .TICK_MS(100), .TW(TW), .MSW(16)) u_slot_timer_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_timeout_ms(req_timeout_ms), .req_periodic(req_periodic),
    .req_handle(req_handle), .ack(ack), .ack_ok(ack_ok), .ack_handle(ack_handle),
    .tick_count(tick_count), .fire_valid(fire_valid), .fire_slot(fire_slot)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int errs = 0;
  int checks = 0;
  int fcount [16];
  int flast  [16];
  int fcyc   [16];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && fire_valid) begin
      fcount[fire_slot]++;
      flast[fire_slot] = tick_count;
      fcyc[fire_slot]  = cyc;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(input bit op, input int ms, input bit per, input int h,
                        output bit ok, output int hd, output int tc);
    @(negedge clk);
    req_valid      = 1'b1;
    req_op         = op;
    req_timeout_ms = ms[15:0];
    req_periodic   = per;
    req_handle     = h[HW-1:0];
    while (!req_ready) @(negedge clk);
    tc = tick_count;
    @(negedge clk);
    req_valid = 1'b0;
    ok = ack_ok;
    hd = ack_handle;
    chk(ack == 1'b1, "R11 ack after accept", ack, 1);
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      int t0;
      t0 = tick_count;
      while (tick_count == t0) @(negedge clk);
    end
    repeat (N + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tick_count == 0, "R2 tick_count in reset", tick_count, 0);
    chk(fire_valid == 0, "R2 fire_valid in reset", fire_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ack == 0, "R2 ack after reset", ack, 0);
    chk(req_ready == 1, "R2 ready after reset", req_ready, 1);
    chk(tick_count == 0, "R2 tick_count after reset", tick_count, 0);
  endtask

  task automatic t_tick_rate();
    int t0, c0, c1;
    t0 = tick_count;
    while (tick_count == t0) @(negedge clk);
    c0 = cyc; t0 = tick_count;
    while (tick_count == t0) @(negedge clk);
    c1 = cyc;
    chk(c1 - c0 == PERIOD, "R1 tick period", c1 - c0, PERIOD);
    chk(tick_count == TW'(t0 + 1), "R1 tick increment", tick_count, (t0 + 1) & 255);
  endtask

  task automatic t_oneshot();
    bit ok; int hd, tc, f0;
    do_req(1'b0, 250, 1'b0, 0, ok, hd, tc);
    chk(ok && hd == 0, "R3 first free slot", hd, 0);
    f0 = fcount[0];
    wait_ticks(4);
    chk(fcount[0] == f0 + 1, "R8 one-shot fires once", fcount[0] - f0, 1);
    chk(flast[0] == ((tc + 2) & 255), "R5 R6 due at tick+2", flast[0], (tc + 2) & 255);
  endtask

  task automatic t_min_periodic();
    bit ok; int hd, tc, c;
    do_req(1'b0, 50, 1'b1, 0, ok, hd, tc);
    chk(ok && hd == 0, "R8 one-shot slot freed and reused", hd, 0);
    c = fcount[0];
    wait_ticks(5);
    chk(fcount[0] == c + 5, "R5 R7 minimum one tick periodic", fcount[0] - c, 5);
    do_req(1'b1, 0, 1'b0, 0, ok, hd, tc);
    chk(ok == 1, "R9 delete in range ok", ok, 1);
    c = fcount[0];
    wait_ticks(3);
    chk(fcount[0] == c, "R9 deleted slot silent", fcount[0] - c, 0);
  endtask

  task automatic t_periodic3();
    bit ok; int hd, tc, c;
    do_req(1'b0, 399, 1'b1, 0, ok, hd, tc);
    c = fcount[0];
    wait_ticks(9);
    chk(fcount[0] == c + 3, "R7 periodic 3 ticks count", fcount[0] - c, 3);
    chk(flast[0] == ((tc + 9) & 255), "R5 R7 round down last expiry", flast[0], (tc + 9) & 255);
    do_req(1'b1, 0, 1'b0, 0, ok, hd, tc);
  endtask

  task automatic t_pool();
    bit ok; int hd, tc;
    for (int i = 0; i < N; i++) begin
      do_req(1'b0, 20000, 1'b0, 0, ok, hd, tc);
      chk(ok && hd == i, "R3 ascending allocation", hd, i);
    end
    do_req(1'b0, 20000, 1'b0, 0, ok, hd, tc);
    chk(ok == 0, "R4 pool full error", ok, 0);
    do_req(1'b1, 0, 1'b0, 12, ok, hd, tc);
    chk(ok == 0, "R9 out of range delete fails", ok, 0);
    do_req(1'b0, 20000, 1'b0, 0, ok, hd, tc);
    chk(ok == 0, "R9 out of range delete changed nothing", ok, 0);
    do_req(1'b1, 0, 1'b0, 3, ok, hd, tc);
    chk(ok == 1, "R9 delete slot 3", ok, 1);
    do_req(1'b0, 20000, 1'b0, 0, ok, hd, tc);
    chk(ok && hd == 3, "R3 lowest free after delete", hd, 3);
    for (int i = 0; i < N; i++) do_req(1'b1, 0, 1'b0, i, ok, hd, tc);
  endtask

  task automatic t_same_tick();
    bit ok; int hd, tc0, tc1, tc2;
    wait_ticks(1);
    do_req(1'b0, 200, 1'b0, 0, ok, hd, tc0);
    do_req(1'b0, 200, 1'b0, 0, ok, hd, tc1);
    do_req(1'b0, 200, 1'b0, 0, ok, hd, tc2);
    chk(hd == 2 && tc0 == tc2, "R3 three slots in one interval", hd, 2);
    wait_ticks(3);
    chk(fcyc[1] == fcyc[0] + 1, "R10 slot1 right after slot0", fcyc[1] - fcyc[0], 1);
    chk(fcyc[2] == fcyc[1] + 1, "R10 slot2 right after slot1", fcyc[2] - fcyc[1], 1);
    chk(flast[2] == ((tc0 + 2) & 255), "R6 same-tick expiry", flast[2], (tc0 + 2) & 255);
  endtask

  task automatic t_collide();
    int t0, low, acks;
    bit ok; int hd, tc;
    t0 = tick_count;
    while (tick_count == t0) @(negedge clk);
    req_valid      = 1'b1;
    req_op         = 1'b0;
    req_timeout_ms = 16'd100;
    req_periodic   = 1'b0;
    low = 0; acks = 0;
    while (!req_ready) begin
      low++;
      if (ack) acks++;
      @(negedge clk);
    end
    chk(low == N, "R11 stall length", low, N);
    chk(acks == 0, "R11 no ack while stalled", acks, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ack == 1 && ack_ok == 1 && ack_handle == 0, "R11 ack after stall", ack_handle, 0);
    do_req(1'b1, 0, 1'b0, 0, ok, hd, tc);
  endtask

  task automatic t_wrap();
    bit ok; int hd, tc, c;
    while (tick_count != 200) @(negedge clk);
    repeat (N + 3) @(negedge clk);
    do_req(1'b0, 10000, 1'b1, 0, ok, hd, tc);
    c = fcount[0];
    wait_ticks(101);
    chk(fcount[0] == c + 1, "R12 wrapped expiry fires once", fcount[0] - c, 1);
    chk(flast[0] == ((tc + 100) & 255) && flast[0] < tc, "R12 wrapped expiry value",
        flast[0], (tc + 100) & 255);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin fcount[i] = 0; flast[i] = 0; fcyc[i] = 0; end
    repeat (4) @(negedge clk);
    t_reset();
    t_tick_rate();
    t_oneshot();
    t_min_periodic();
    t_periodic3();
    t_pool();
    t_same_tick();
    t_collide();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule